// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps the time of day and the calendar in packed BCD: seconds, minutes, hours (24-hour), day of week, date, month, two-digit year and a two-digit century. A binary prescaler divides the input clock down to one tick per second. Each tick advances the seconds and ripples carries up through the fields in the same clock cycle. Month lengths are handled automatically, and February gets a 29th day in every year whose number is a multiple of four.

A stop input freezes both the prescaler and the counters. A load strobe writes every field at once from parallel BCD inputs and restarts the prescaler, so the next second begins on the load edge. For a frequency check, a square wave taken from one prescaler bit can replace bit 0 of the seconds output while the counter runs. The same wave is also available on its own pin. Loaded values are assumed to be legal BCD within each field's range, with a date that exists in the loaded month.

Top module: `bcd_rtc`

## Requirements
- R1: While `rst` is high, the outputs go on the next clock edge to 00:00:00, day of week 01, date 01, month 01, year 00, century 00. With frequency test off, `sq_o` is 0.
- R2: While running, seconds advance by one exactly DIV clock edges after a load, and then every DIV edges. Seconds and minutes count 00 to 59, and 59 wraps to 00 with a carry into the next field.
- R3: Hours count 00 to 23. A carry out of 23 wraps hours to 00 and starts a new day.
- R4: On each new day the day of week steps by one, and 07 wraps to 01.
- R5: On each new day the date steps by one. After 30 in April, June, September and November, and after 31 in the other months except February, it wraps to 01 and the month advances.
- R6: February ends on 29 when the year (BCD, read as 00 to 99) is divisible by four, 00 included, and on 28 otherwise.
- R7: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and carries into the century. Century 39 wraps to 00.
- R8: While `stop_i` is 1, no field changes and the prescaler holds its count. Counting resumes from that count when `stop_i` returns to 0.
- R9: `load_i` overwrites all eight fields on the next edge and clears the prescaler to 0. It takes priority over a tick arriving on the same edge.
- R10: When `ftest_en_i` is 1 and `stop_i` is 0, bit 0 of `sec_o` and `sq_o` both show bit TEST_BIT of the prescaler count. That bit is high for counts 32 to 63 of each 64-count span with the default TEST_BIT of 5. Otherwise `sec_o` shows the true seconds and `sq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock (DIV cycles per second) |
| rst | input | 1 | Synchronous active-high reset |
| stop_i | input | 1 | 1 halts prescaler and counters |
| ftest_en_i | input | 1 | Enables the square-wave test output |
| load_i | input | 1 | Loads all fields and clears the prescaler |
| ld_sec_i | input | 8 | BCD seconds to load |
| ld_min_i | input | 8 | BCD minutes to load |
| ld_hour_i | input | 8 | BCD hours to load |
| ld_dow_i | input | 8 | BCD day of week to load |
| ld_date_i | input | 8 | BCD date to load |
| ld_month_i | input | 8 | BCD month to load |
| ld_year_i | input | 8 | BCD year to load |
| ld_cent_i | input | 8 | BCD century to load |
| sec_o | output | 8 | BCD seconds (bit 0 may carry the test wave) |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours |
| dow_o | output | 8 | BCD day of week |
| date_o | output | 8 | BCD date |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD year |
| cent_o | output | 8 | BCD century |
| sq_o | output | 1 | Test square wave, 0 when inactive |

## Verification
The range assertions on each field rely on every load carrying legal BCD within that field's range. They also rely on a loaded date that exists in the loaded month, since the counter never repairs an out-of-range value. The bench keeps a plain integer model of the calendar and turns it into BCD only when it drives a load or forms an expected value. Every load it issues therefore comes from a legal date and time. Its corner cases reach the wraps by loading the instant just before them, such as 23:59:59 on the last day of a month or of a century.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

    typedef logic [7:0] bcd_t;

    typedef struct packed {
        bcd_t hour;
        bcd_t min;
        bcd_t sec;
    } tod_t;

    typedef struct packed {
        bcd_t cent;
        bcd_t year;
        bcd_t month;
        bcd_t date;
        bcd_t dow;
    } cal_t;

    typedef struct packed {
        bcd_t val;
        logic wrap;
    } step_t;

    localparam bcd_t SEC_LAST   = 8'h59;
    localparam bcd_t MIN_LAST   = 8'h59;
    localparam bcd_t HOUR_LAST  = 8'h23;
    localparam bcd_t DOW_FIRST  = 8'h01;
    localparam bcd_t DOW_LAST   = 8'h07;
    localparam bcd_t DATE_FIRST = 8'h01;
    localparam bcd_t MON_FIRST  = 8'h01;
    localparam bcd_t MON_LAST   = 8'h12;
    localparam bcd_t YEAR_LAST  = 8'h99;
    localparam bcd_t CENT_LAST  = 8'h39;
    localparam bcd_t ZERO_BCD   = 8'h00;

    localparam tod_t TOD_RESET = {ZERO_BCD, ZERO_BCD, ZERO_BCD};
    localparam cal_t CAL_RESET = {ZERO_BCD, ZERO_BCD, MON_FIRST, DATE_FIRST, DOW_FIRST};

    // Advance one packed-BCD field; returns the first value and a wrap flag at the last one.
    function automatic step_t bcd_step(bcd_t v, bcd_t last, bcd_t first);
        step_t r;
        if (v == last) begin
            r.val  = first;
            r.wrap = 1'b1;
        end else begin
            r.wrap = 1'b0;
            if (v[3:0] == 4'h9) r.val = {v[7:4] + 4'h1, 4'h0};
            else                r.val = {v[7:4], v[3:0] + 4'h1};
        end
        return r;
    endfunction

    function automatic logic [6:0] bcd_to_bin(bcd_t v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    function automatic logic year_is_leap(bcd_t year);
        logic [6:0] b;
        b = bcd_to_bin(year);
        return (b[1:0] == 2'b00);
    endfunction

    function automatic bcd_t month_last_day(bcd_t month, bcd_t year);
        case (month)
            8'h02:                      return year_is_leap(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV      = 32768,
    parameter int TEST_BIT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic clear_i,
    output logic tick_o,
    output logic test_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i)  cnt_q <= '0;
        else if (run_i)      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign tick_o = run_i && (cnt_q == LAST);

    generate
        if (TEST_BIT < CW) begin : g_tap
            assign test_o = cnt_q[TEST_BIT];
        end else begin : g_no_tap
            assign test_o = 1'b0;
        end
    endgenerate

    // R8: a stopped prescaler keeps its count
    a_r8_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !clear_i) |=> $stable(cnt_q));

    // R9: a load restarts the second
    a_r9_clear_count: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_tod.sv
module rtc_tod
    import bcd_rtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic load_i,
    input  tod_t load_val_i,
    output tod_t tod_o,
    output logic day_o
);
    tod_t  q, nxt;
    step_t s_st, m_st, h_st;

    always_comb begin
        s_st = bcd_step(q.sec,  SEC_LAST,  ZERO_BCD);
        m_st = bcd_step(q.min,  MIN_LAST,  ZERO_BCD);
        h_st = bcd_step(q.hour, HOUR_LAST, ZERO_BCD);
        nxt  = q;
        if (tick_i) begin
            nxt.sec = s_st.val;
            if (s_st.wrap) begin
                nxt.min = m_st.val;
                if (m_st.wrap) nxt.hour = h_st.val;
            end
        end
    end

    assign day_o = tick_i && s_st.wrap && m_st.wrap && h_st.wrap;

    always_ff @(posedge clk) begin
        if (rst)         q <= TOD_RESET;
        else if (load_i) q <= load_val_i;
        else             q <= nxt;
    end

    assign tod_o = q;

    // R2: seconds stay legal BCD within 00..59
    a_r2_sec_legal: assert property (@(posedge clk) disable iff (rst)
        (q.sec <= SEC_LAST) && (q.sec[3:0] <= 4'h9));

    // R2: without a tick or load the time holds
    a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !load_i) |=> $stable(q));

    // R3: hours never pass 23
    a_r3_hour_legal: assert property (@(posedge clk) disable iff (rst)
        q.hour <= HOUR_LAST);

    // R3: a day carry lands on midnight
    a_r3_midnight: assert property (@(posedge clk) disable iff (rst)
        (day_o && !load_i) |=> (q == TOD_RESET));

endmodule

// File: rtl/rtc_date.sv
module rtc_date
    import bcd_rtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic day_i,
    input  logic load_i,
    input  cal_t load_val_i,
    output cal_t cal_o
);
    cal_t  q, nxt;
    bcd_t  last_date;
    step_t w_st, d_st, mo_st, y_st, c_st;

    always_comb begin
        last_date = month_last_day(q.month, q.year);
        w_st  = bcd_step(q.dow,   DOW_LAST,  DOW_FIRST);
        d_st  = bcd_step(q.date,  last_date, DATE_FIRST);
        mo_st = bcd_step(q.month, MON_LAST,  MON_FIRST);
        y_st  = bcd_step(q.year,  YEAR_LAST, ZERO_BCD);
        c_st  = bcd_step(q.cent,  CENT_LAST, ZERO_BCD);
        nxt   = q;
        if (day_i) begin
            nxt.dow  = w_st.val;
            nxt.date = d_st.val;
            if (d_st.wrap) begin
                nxt.month = mo_st.val;
                if (mo_st.wrap) begin
                    nxt.year = y_st.val;
                    if (y_st.wrap) nxt.cent = c_st.val;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         q <= CAL_RESET;
        else if (load_i) q <= load_val_i;
        else             q <= nxt;
    end

    assign cal_o = q;

    // R4: day of week stays within 01..07
    a_r4_dow_legal: assert property (@(posedge clk) disable iff (rst)
        (q.dow >= DOW_FIRST) && (q.dow <= DOW_LAST));

    // R4: a new day after day 07 starts the week over
    a_r4_dow_wrap: assert property (@(posedge clk) disable iff (rst)
        (day_i && !load_i && q.dow == DOW_LAST) |=> (q.dow == DOW_FIRST));

    // R5: the calendar holds between day carries
    a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
        (!day_i && !load_i) |=> $stable(q));

    // R6: February never shows a day beyond 29
    a_r6_feb_limit: assert property (@(posedge clk) disable iff (rst)
        (q.month == 8'h02) |-> (q.date <= 8'h29));

    // R7: century never passes 39
    a_r7_cent_legal: assert property (@(posedge clk) disable iff (rst)
        q.cent <= CENT_LAST);

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import bcd_rtc_pkg::*;
#(
    parameter int DIV      = 32768,
    parameter int TEST_BIT = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_i,
    input  logic       ftest_en_i,
    input  logic       load_i,
    input  logic [7:0] ld_sec_i,
    input  logic [7:0] ld_min_i,
    input  logic [7:0] ld_hour_i,
    input  logic [7:0] ld_dow_i,
    input  logic [7:0] ld_date_i,
    input  logic [7:0] ld_month_i,
    input  logic [7:0] ld_year_i,
    input  logic [7:0] ld_cent_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [7:0] cent_o,
    output logic       sq_o
);
    logic run, tick, day_carry, wave, test_on;
    tod_t tod, ld_tod;
    cal_t cal, ld_cal;

    assign run     = !stop_i;
    assign test_on = ftest_en_i && run;
    assign ld_tod  = {ld_hour_i, ld_min_i, ld_sec_i};
    assign ld_cal  = {ld_cent_i, ld_year_i, ld_month_i, ld_date_i, ld_dow_i};

    rtc_prescaler #(.DIV(DIV), .TEST_BIT(TEST_BIT)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run),
        .clear_i (load_i),
        .tick_o  (tick),
        .test_o  (wave)
    );

    rtc_tod u_tod (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .load_i     (load_i),
        .load_val_i (ld_tod),
        .tod_o      (tod),
        .day_o      (day_carry)
    );

    rtc_date u_date (
        .clk        (clk),
        .rst        (rst),
        .day_i      (day_carry),
        .load_i     (load_i),
        .load_val_i (ld_cal),
        .cal_o      (cal)
    );

    assign sec_o   = test_on ? {tod.sec[7:1], wave} : tod.sec;
    assign min_o   = tod.min;
    assign hour_o  = tod.hour;
    assign dow_o   = cal.dow;
    assign date_o  = cal.date;
    assign month_o = cal.month;
    assign year_o  = cal.year;
    assign cent_o  = cal.cent;
    assign sq_o    = test_on && wave;

    // R10: the test wave is silent unless enabled and running
    a_r10_wave_gated: assert property (@(posedge clk) disable iff (rst)
        !test_on |-> !sq_o);

endmodule

// File: tb/bcd_rtc_tb.sv
module bcd_rtc_tb;
    localparam int DIV = 64;

    logic clk = 1'b0, rst = 1'b1, stop_i = 1'b0, ftest_en_i = 1'b0, load_i = 1'b0;
    logic [7:0] ld_sec_i = 0, ld_min_i = 0, ld_hour_i = 0, ld_dow_i = 0;
    logic [7:0] ld_date_i = 0, ld_month_i = 0, ld_year_i = 0, ld_cent_i = 0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, cent_o;
    logic sq_o;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    bcd_rtc #(.DIV(DIV), .TEST_BIT(5)) u_dut (
        .clk(clk), .rst(rst), .stop_i(stop_i), .ftest_en_i(ftest_en_i), .load_i(load_i),
        .ld_sec_i(ld_sec_i), .ld_min_i(ld_min_i), .ld_hour_i(ld_hour_i), .ld_dow_i(ld_dow_i),
        .ld_date_i(ld_date_i), .ld_month_i(ld_month_i), .ld_year_i(ld_year_i), .ld_cent_i(ld_cent_i),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o),
        .month_o(month_o), .year_o(year_o), .cent_o(cent_o), .sq_o(sq_o)
    );

    // integer reference model
    int ms, mm, mh, mw, md, mmo, my, mc;

    typedef struct {
        logic [7:0] f[8];
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int days_in(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mw = (mw == 7) ? 1 : mw + 1;
                    md++;
                    if (md > days_in(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin
                            mmo = 1; my++;
                            if (my == 100) begin
                                my = 0; mc = (mc == 39) ? 0 : mc + 1;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic check(string tag, string what, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // driver: push expected values from the model and signal the monitor
    task automatic expect_now(string tag);
        exp_t e;
        e.tag  = tag;
        e.f[0] = to_bcd(ms); e.f[1] = to_bcd(mm); e.f[2] = to_bcd(mh); e.f[3] = to_bcd(mw);
        e.f[4] = to_bcd(md); e.f[5] = to_bcd(mmo); e.f[6] = to_bcd(my); e.f[7] = to_bcd(mc);
        exp_q.push_back(e);
        ->sample_ev;
        #1;
    endtask

    // monitor: pop and compare against the outputs
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [7:0] act[8];
                e = exp_q.pop_front();
                act = '{sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, cent_o};
                for (int i = 0; i < 8; i++) begin
                    string nm[8] = '{"sec", "min", "hour", "dow", "date", "month", "year", "cent"};
                    check(e.tag, nm[i], act[i], e.f[i]);
                end
            end
        end
    end

    task automatic wait_clks(int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a falling edge; the load edge is the next rising edge
    task automatic do_load(int c, int y, int mo, int d, int w, int h, int m, int s);
        mc = c; my = y; mmo = mo; md = d; mw = w; mh = h; mm = m; ms = s;
        ld_cent_i = to_bcd(c); ld_year_i = to_bcd(y); ld_month_i = to_bcd(mo);
        ld_date_i = to_bcd(d); ld_dow_i = to_bcd(w); ld_hour_i = to_bcd(h);
        ld_min_i = to_bcd(m); ld_sec_i = to_bcd(s);
        load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic wait_secs(int n, string tag);
        for (int i = 0; i < n; i++) begin
            wait_clks(DIV);
            model_step();
        end
        expect_now(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        if (!done) begin
            // R1 reset values
            mc = 0; my = 0; mmo = 1; md = 1; mw = 1; mh = 0; mm = 0; ms = 0;
            expect_now("R1 reset");
            check("R1 reset", "sq", sq_o, 0);
            rst = 1'b0;

            // R2 plain seconds and minute carry
            do_load(20, 23, 6, 15, 3, 12, 34, 56);
            expect_now("R9 load value");
            wait_secs(1, "R2 one second");
            wait_secs(4, "R2 minute carry");

            // R3 R4 R7 full rollover into a new century
            do_load(19, 99, 12, 31, 7, 23, 59, 58);
            wait_secs(1, "R2 to 59");
            wait_secs(1, "R3 R4 R7 new century");

            // R5 thirty-day month
            do_load(20, 23, 4, 30, 2, 23, 59, 59);
            wait_secs(1, "R5 april end");
            do_load(20, 23, 1, 31, 5, 23, 59, 59);
            wait_secs(1, "R5 january end");

            // R6 February lengths
            do_load(20, 23, 2, 28, 1, 23, 59, 59);
            wait_secs(1, "R6 common year");
            do_load(20, 24, 2, 28, 1, 23, 59, 59);
            wait_secs(1, "R6 leap 28");
            do_load(20, 24, 2, 29, 2, 23, 59, 59);
            wait_secs(1, "R6 leap 29");
            do_load(21, 0, 2, 28, 4, 23, 59, 59);
            wait_secs(1, "R6 year 00");

            // R7 century wrap
            do_load(39, 99, 12, 31, 6, 23, 59, 59);
            wait_secs(1, "R7 century 39");

            // R8 stop holds fields and prescaler
            stop_i = 1'b1;
            do_load(20, 25, 3, 10, 1, 10, 0, 0);
            wait_clks(3 * DIV);
            expect_now("R8 stopped");
            stop_i = 1'b0;
            wait_secs(1, "R8 resume");

            // R9 load clears the prescaler
            do_load(20, 25, 3, 10, 1, 8, 0, 0);
            wait_clks(DIV / 2);
            do_load(20, 25, 3, 10, 1, 9, 30, 0);
            wait_clks(DIV - 1);
            expect_now("R9 cleared no tick yet");
            wait_clks(1);
            model_step();
            expect_now("R9 tick after full second");

            // R9 load beats a same-edge tick
            do_load(20, 25, 3, 10, 1, 9, 0, 0);
            wait_clks(DIV - 1);
            do_load(20, 25, 5, 5, 4, 5, 5, 5);
            expect_now("R9 load priority");

            // R10 test wave on bit 0
            ftest_en_i = 1'b1;
            do_load(20, 25, 3, 10, 1, 7, 0, 0);
            wait_clks(40);
            check("R10 wave high", "sec0", sec_o[0], 1);
            check("R10 wave high", "sq", sq_o, 1);
            wait_clks(30);
            check("R10 wave low", "sec0", sec_o[0], 0);
            check("R10 wave low", "sec_hi", sec_o[7:1], 0);
            stop_i = 1'b1;
            #1;
            check("R10 stopped", "sec", sec_o, 8'h01);
            check("R10 stopped", "sq", sq_o, 0);
            stop_i = 1'b0;
            ftest_en_i = 1'b0;
            #1;
            check("R10 disabled", "sq", sq_o, 0);
            check("R10 disabled", "sec", sec_o, 8'h01);

            #1;
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule